// File: doc/BRIEF.md
# Two-Event Classification Sequence Detector

This block watches the voltage on a powered-device port, delivered as a millivolt word from an external converter together with a sample-valid strobe. It sorts each sample into a voltage zone and accepts a new zone only after several samples in a row agree. It then tracks the pattern the supplying equipment draws on the line. A classification interval followed by a falling excursion into the mark window counts as one event. Two such pairs identify a type-2 source. Anything less leaves the source treated as type 1.

Any drop into the reset zone wipes the progress. Once the under-voltage lockout reports the port as powered, the result is frozen. An active-low indicator is pulled low only when a two-event sequence was recognised and the downstream converter is running. Reset is asynchronous and active low; it is expected to be released synchronously by the surrounding logic.

Top module: `cls_seq_detect`

## Requirements
- R1: Samples are sorted into zones by millivolt value. Below 4900 is the reset zone. 5400 to 9700 inclusive is the mark zone. 13000 to 20500 inclusive is the class zone. Values from 4900 to 5399, from 9701 to 12999 and above 20500 are hold zones.
- R2: A zone is evaluated only on cycles where `smp_vld_i` is high. Samples presented without the strobe have no effect.
- R3: After reset, a class zone followed by a mark zone sets `evt_cnt_o` to 1.
- R4: A second class-then-mark pair sets `evt_cnt_o` to 2 and raises `type2_o`.
- R5: Further class and mark pairs leave `evt_cnt_o` at 2 and `type2_o` at 1. The count never exceeds 2 and never rises by more than 1 per cycle.
- R6: A mark zone that is not preceded by a class zone (classification skipped) is not counted.
- R7: An accepted reset zone, while `uvlo_on_i` is low, returns `evt_cnt_o` to 0 and `type2_o` to 0.
- R8: Hold zones change nothing. A class zone followed by a hold zone and then a mark zone still counts as one event.
- R9: While `uvlo_on_i` is high, and afterwards until a reset zone is accepted with `uvlo_on_i` low, non-reset zones do not change the count.
- R10: `hp_n_o` is 0 exactly when `type2_o` is 1 and `conv_run_i` is 1. Otherwise it is 1.
- R11: After reset, `evt_cnt_o` is 0, `type2_o` is 0 and `hp_n_o` is 1.
- R12: A new zone is accepted only after 4 consecutive valid samples fall in it. A run of 3 does not change the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld_i | input | 1 | Port-voltage sample valid strobe |
| port_mv_i | input | 16 | Port voltage in millivolts |
| uvlo_on_i | input | 1 | Under-voltage lockout reports port powered |
| conv_run_i | input | 1 | Downstream converter is supplying the application |
| evt_cnt_o | output | 2 | Counted class-mark events, saturating at 2 |
| type2_o | output | 1 | Two-event classification recognised |
| hp_n_o | output | 1 | Active-low high-power indicator |

## Verification
The hardest situation to reach is the set of almost-sequences. Examples are a class run one sample short of acceptance, a mark that arrives before any class, and a freeze that is lifted with the voltage still outside the reset zone. None of these shows at the outputs unless a later stimulus would have advanced the count. Directed segments therefore follow each near-miss with the zone that would expose a wrong state change, and they probe the exact zone edges (4899/4900, 9700/9701, 12999/13000). A seeded random walk over all six zones, with run lengths of 4 to 6 and a randomly toggled converter-running input, is compared after every segment against a reference sequence model kept in the bench.

// File: rtl/cls_pkg.sv
package cls_pkg;
  typedef enum logic [2:0] {
    Z_RST   = 3'd0,
    Z_LOW   = 3'd1,
    Z_MARK  = 3'd2,
    Z_GAP   = 3'd3,
    Z_CLASS = 3'd4,
    Z_HIGH  = 3'd5
  } zone_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_CLS1 = 3'd1,
    S_MRK1 = 3'd2,
    S_CLS2 = 3'd3,
    S_MRK2 = 3'd4
  } seq_e;
endpackage

// File: rtl/cls_zone_map.sv
module cls_zone_map
  import cls_pkg::*;
#(
  parameter int VW     = 16,
  parameter int RST_MV = 4900,
  parameter int MRK_LO = 5400,
  parameter int MRK_HI = 9700,
  parameter int CLS_LO = 13000,
  parameter int CLS_HI = 20500
) (
  input  logic [VW-1:0] mv_i,
  output zone_e         zone_o
);
  localparam logic [VW-1:0] K_RST  = VW'(RST_MV);
  localparam logic [VW-1:0] K_MLO  = VW'(MRK_LO);
  localparam logic [VW-1:0] K_MHI  = VW'(MRK_HI);
  localparam logic [VW-1:0] K_CLO  = VW'(CLS_LO);
  localparam logic [VW-1:0] K_CHI  = VW'(CLS_HI);

  always_comb begin
    if (mv_i < K_RST)       zone_o = Z_RST;
    else if (mv_i < K_MLO)  zone_o = Z_LOW;
    else if (mv_i <= K_MHI) zone_o = Z_MARK;
    else if (mv_i < K_CLO)  zone_o = Z_GAP;
    else if (mv_i <= K_CHI) zone_o = Z_CLASS;
    else                    zone_o = Z_HIGH;
  end
endmodule

// File: rtl/cls_zone_filter.sv
module cls_zone_filter
  import cls_pkg::*;
#(
  parameter int DEB_N = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  vld_i,
  input  zone_e zone_i,
  output zone_e stable_o
);
  localparam int RW = $clog2(DEB_N + 1);
  localparam logic [RW-1:0] RUN_MAX = RW'(DEB_N);

  zone_e         cand_q, cand_d, stable_q, stable_d;
  logic [RW-1:0] run_q, run_d;

  always_comb begin
    cand_d   = cand_q;
    run_d    = run_q;
    stable_d = stable_q;
    if (vld_i) begin
      if (zone_i != cand_q) begin
        cand_d = zone_i;
        run_d  = RW'(1);
      end else if (run_q != RUN_MAX) begin
        run_d  = run_q + RW'(1);
      end
      if (run_d >= RUN_MAX) stable_d = cand_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q   <= Z_RST;
      run_q    <= '0;
      stable_q <= Z_RST;
    end else if (vld_i) begin
      cand_q   <= cand_d;
      run_q    <= run_d;
      stable_q <= stable_d;
    end
  end

  assign stable_o = stable_q;

  p_no_strobe_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> $stable(stable_q));

  p_accept_needs_run_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && (zone_i != cand_q)) |=> (stable_q == $past(stable_q)) || (DEB_N == 1));
endmodule

// File: rtl/cls_seq_fsm.sv
module cls_seq_fsm
  import cls_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  zone_e      zone_i,
  input  logic       uvlo_on_i,
  output logic [1:0] cnt_o,
  output logic       type2_o
);
  seq_e st_q, st_d;
  logic frz_q, frz_d;
  logic hold_w;

  assign hold_w = frz_q | uvlo_on_i;

  always_comb begin
    st_d  = st_q;
    frz_d = hold_w;
    if (zone_i == Z_RST && !uvlo_on_i) begin
      st_d  = S_IDLE;
      frz_d = 1'b0;
    end else if (!hold_w) begin
      unique case (st_q)
        S_IDLE:  if (zone_i == Z_CLASS) st_d = S_CLS1;
        S_CLS1:  if (zone_i == Z_MARK)  st_d = S_MRK1;
        S_MRK1:  if (zone_i == Z_CLASS) st_d = S_CLS2;
        S_CLS2:  if (zone_i == Z_MARK)  st_d = S_MRK2;
        S_MRK2:  st_d = S_MRK2;
        default: st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      frz_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      frz_q <= frz_d;
    end
  end

  always_comb begin
    unique case (st_q)
      S_MRK1, S_CLS2: cnt_o = 2'd1;
      S_MRK2:         cnt_o = 2'd2;
      default:        cnt_o = 2'd0;
    endcase
  end

  assign type2_o = (st_q == S_MRK2);

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_o != 2'd3);

  p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_o > $past(cnt_o)) |-> (cnt_o == $past(cnt_o) + 2'd1));

  p_freeze_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (uvlo_on_i) |=> $stable(st_q));

  p_reset_zone_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (zone_i == Z_RST && !uvlo_on_i) |=> (cnt_o == 2'd0 && !type2_o));

  p_type2_via_second_class_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(type2_o)) |-> ($past(st_q) == S_CLS2));
endmodule

// File: rtl/cls_seq_detect.sv
module cls_seq_detect
  import cls_pkg::*;
#(
  parameter int VW     = 16,
  parameter int DEB_N  = 4,
  parameter int RST_MV = 4900,
  parameter int MRK_LO = 5400,
  parameter int MRK_HI = 9700,
  parameter int CLS_LO = 13000,
  parameter int CLS_HI = 20500
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld_i,
  input  logic [VW-1:0] port_mv_i,
  input  logic          uvlo_on_i,
  input  logic          conv_run_i,
  output logic [1:0]    evt_cnt_o,
  output logic          type2_o,
  output logic          hp_n_o
);
  zone_e raw_zone, acc_zone;

  cls_zone_map #(
    .VW(VW), .RST_MV(RST_MV), .MRK_LO(MRK_LO), .MRK_HI(MRK_HI),
    .CLS_LO(CLS_LO), .CLS_HI(CLS_HI)
  ) u_map (
    .mv_i  (port_mv_i),
    .zone_o(raw_zone)
  );

  cls_zone_filter #(.DEB_N(DEB_N)) u_filt (
    .clk     (clk),
    .rst_n   (rst_n),
    .vld_i   (smp_vld_i),
    .zone_i  (raw_zone),
    .stable_o(acc_zone)
  );

  cls_seq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .zone_i   (acc_zone),
    .uvlo_on_i(uvlo_on_i),
    .cnt_o    (evt_cnt_o),
    .type2_o  (type2_o)
  );

  assign hp_n_o = ~(type2_o & conv_run_i);

  p_flag_needs_two_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!hp_n_o) |-> (evt_cnt_o == 2'd2));
endmodule

// File: tb/sim_cls_seq_detect.sv
module sim_cls_seq_detect;
  localparam int PERIOD = 10;

  logic        clk, rst_n, vld, uvlo, crun;
  logic [15:0] mv;
  logic [1:0]  cnt;
  logic        t2, hpn;
  int n_chk, n_fail;
  int ph;

  cls_seq_detect u0 (
    .clk(clk), .rst_n(rst_n), .smp_vld_i(vld), .port_mv_i(mv),
    .uvlo_on_i(uvlo), .conv_run_i(crun),
    .evt_cnt_o(cnt), .type2_o(t2), .hp_n_o(hpn)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  // zone codes: 0 reset,1 low hold,2 mark,3 gap hold,4 class,5 high hold
  function automatic int zone_of(int v);
    if (v < 4900) return 0;
    if (v < 5400) return 1;
    if (v <= 9700) return 2;
    if (v < 13000) return 3;
    if (v <= 20500) return 4;
    return 5;
  endfunction

  function automatic int next_ph(int p, int z);
    if (z == 0) return 0;
    if (p == 0 && z == 4) return 1;
    if (p == 1 && z == 2) return 2;
    if (p == 2 && z == 4) return 3;
    if (p == 3 && z == 2) return 4;
    return p;
  endfunction

  function automatic int cnt_of(int p);
    if (p == 4) return 2;
    if (p >= 2) return 1;
    return 0;
  endfunction

  function automatic int pick_mv(int z);
    case (z)
      0: return $urandom % 4900;
      1: return 4900 + $urandom % 500;
      2: return 5400 + $urandom % 4301;
      3: return 9701 + $urandom % 3299;
      4: return 13000 + $urandom % 7501;
      default: return 20501 + $urandom % 20000;
    endcase
  endfunction

  task automatic drive(int v, int n, bit strobe = 1'b1);
    repeat (n) begin
      @(negedge clk);
      vld = strobe;
      mv  = 16'(v);
    end
    @(negedge clk);
    vld = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_all(string tag, int exp_cnt);
    chk(tag, int'(cnt), exp_cnt);
    chk(tag, int'(t2), (exp_cnt == 2) ? 1 : 0);
    chk({tag, "/R10"}, int'(hpn), (exp_cnt == 2 && crun) ? 0 : 1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0;
    vld = 0; mv = 0; uvlo = 0; crun = 0; rst_n = 0;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk_all("R11 reset", 0);
    rst_n = 1;
    @(negedge clk);

    // R3, R4, R10: clean two-event sequence
    drive(16000, 4); drive(7000, 4);
    chk_all("R3 one pair", 1);
    drive(16000, 4); drive(7000, 4);
    chk_all("R4 two pairs", 2);
    crun = 1; @(negedge clk);
    chk_all("R10 flag low", 2);
    // R5: extra pairs
    drive(18000, 5); drive(6000, 5);
    chk_all("R5 extra pair", 2);
    crun = 0; @(negedge clk);
    chk_all("R10 conv off", 2);

    // R7: reset zone clears
    drive(1000, 4);
    chk_all("R7 reset zone", 0);

    // R6: mark without class
    drive(8000, 4);
    chk_all("R6 skipped class", 0);
    drive(14000, 4); drive(8000, 4);
    chk_all("R6 then pair", 1);
    drive(1000, 4);

    // R1 boundaries, R8 hold zones
    drive(13000, 4); drive(11000, 4); drive(9700, 4);
    chk_all("R1 R8 edge class/gap/mark", 1);
    drive(12999, 4); drive(9701, 4);
    chk_all("R1 gap edges hold", 1);
    drive(20501, 4); drive(9000, 4);
    chk_all("R1 above class holds", 1);
    drive(4900, 4);
    chk_all("R1 4900 holds", 1);
    drive(4899, 4);
    chk_all("R1 4899 resets", 0);

    // R12: three-sample run rejected
    drive(15000, 3); drive(1000, 4); drive(8000, 4);
    chk_all("R12 short run", 0);
    // R2: unstrobed samples ignored
    drive(15000, 8, 1'b0); drive(8000, 4);
    chk_all("R2 no strobe", 0);
    drive(20500, 4); drive(5400, 4);
    chk_all("R1 R12 exact edges", 1);

    // R9: freeze
    uvlo = 1;
    drive(15000, 4); drive(8000, 4);
    chk_all("R9 frozen uvlo high", 1);
    drive(1000, 4);
    chk_all("R9 reset ignored under uvlo", 1);
    uvlo = 0;
    drive(15000, 4); drive(8000, 4);
    chk_all("R9 frozen after uvlo", 1);
    drive(1000, 4);
    chk_all("R9 R7 unfreeze", 0);

    // random walk against the reference model (R3 R5 R8 R10)
    ph = 0;
    for (int i = 0; i < 60; i++) begin
      int z;
      z = $urandom % 6;
      crun = $urandom % 2;
      drive(pick_mv(z), 4 + $urandom % 3);
      ph = next_ph(ph, z);
      chk_all("R5 random walk", cnt_of(ph));
    end

    finish_run();
  end
endmodule